// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory of 2^15 words and watches the enable and address inputs of both ports. When both ports are enabled and present the same address, it grants the access to the port whose inputs settled first. It flags the other port with an active-low busy signal, and it suppresses that port's write strobe. Order is tracked by noting which port changed its address or enable most recently. If both ports change in the same cycle, the left port is granted.

The block has two modes. In master mode it drives both busy outputs itself. In slave mode it holds its busy outputs inactive and accepts an external busy input per port. That input only gates the matching port's write. The cleaned write strobes it produces go straight to the memory array.

Top module: `dp_collision_arb`

## Requirements
- R1: In master mode a busy output (active low) goes low only in the cycle after a clock edge at which both enables were high and both addresses were equal.
- R2: If at a clock edge either enable is low, or the addresses differ, both busy outputs are high (1) after that edge.
- R3: On a match, the port whose address or enable changed at the more recent clock edge gets its busy output low. The port that settled earlier keeps busy high. While neither port changes, the earlier decision is held.
- R4: If both ports change address or enable at the same clock edge and then match, the left port is granted and the right busy goes low.
- R5: `busy_l_n_o` and `busy_r_n_o` are never low at the same time.
- R6: In master mode a port's write output equals its write request ANDed with its own busy output. A port whose busy is low has its write suppressed, and a port whose busy is high passes its write unchanged.
- R7: In slave mode (`master_i` = 0 at a clock edge), both busy outputs are high after that edge. Each port's write output is its write request ANDed with its external busy input `busy_x_n_i`, where a low input blocks the write.
- R8: Busy returns high in the first cycle after the edge at which the addresses stop matching or an enable drops.
- R9: During and right after reset, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_i | input | 1 | 1 = master mode (drive busy), 0 = slave mode |
| l_en_i | input | 1 | Left port enable |
| l_addr_i | input | AW | Left port word address |
| l_we_i | input | 1 | Left port write request |
| r_en_i | input | 1 | Right port enable |
| r_addr_i | input | AW | Right port word address |
| r_we_i | input | 1 | Right port write request |
| busy_l_n_i | input | 1 | External left busy (slave mode), active low |
| busy_r_n_i | input | 1 | External right busy (slave mode), active low |
| busy_l_n_o | output | 1 | Left busy flag, active low |
| busy_r_n_o | output | 1 | Right busy flag, active low |
| l_we_o | output | 1 | Left write after inhibition |
| r_we_o | output | 1 | Right write after inhibition |

## Verification
The arrival decision and the write inhibition meet in one cycle. A port that has just become the later arrival gets its busy output and its blocked write in the same cycle its write request is presented. The bench provokes this with directed sequences: one side settles first, the other side moves onto the same address with a write request, and then both sides move together. Random steps over a narrow address set mix modes, enables and writes. Each cycle's busy flags and gated writes are compared with a bench model of the ordering rules.

// File: rtl/dp_collision_arb.sv
module dp_collision_arb #(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_i,
  input  logic          l_en_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_we_i,
  input  logic          r_en_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_we_i,
  input  logic          busy_l_n_i,
  input  logic          busy_r_n_i,
  output logic          busy_l_n_o,
  output logic          busy_r_n_o,
  output logic          l_we_o,
  output logic          r_we_o
);

  logic [AW-1:0] l_addr_q, r_addr_q;
  logic          l_en_q, r_en_q;
  logic          r_first_q;
  logic          busy_l_q, busy_r_q;

  logic l_chg, r_chg, r_first_d, hit;

  assign l_chg = (l_addr_i != l_addr_q) || (l_en_i != l_en_q);
  assign r_chg = (r_addr_i != r_addr_q) || (r_en_i != r_en_q);
  assign hit   = master_i && l_en_i && r_en_i && (l_addr_i == r_addr_i);

  always_comb begin
    r_first_d = r_first_q;
    if (r_chg)      r_first_d = 1'b0;
    else if (l_chg) r_first_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_addr_q  <= '0;
      r_addr_q  <= '0;
      l_en_q    <= 1'b0;
      r_en_q    <= 1'b0;
      r_first_q <= 1'b0;
      busy_l_q  <= 1'b1;
      busy_r_q  <= 1'b1;
    end else begin
      l_addr_q  <= l_addr_i;
      r_addr_q  <= r_addr_i;
      l_en_q    <= l_en_i;
      r_en_q    <= r_en_i;
      r_first_q <= r_first_d;
      busy_l_q  <= !(hit && r_first_d);
      busy_r_q  <= !(hit && !r_first_d);
    end
  end

  assign busy_l_n_o = busy_l_q;
  assign busy_r_n_o = busy_r_q;
  assign l_we_o = l_we_i && (master_i ? busy_l_q : busy_l_n_i);
  assign r_we_o = r_we_i && (master_i ? busy_r_q : busy_r_n_i);

  // R5
  never_both_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_l_n_o || busy_r_n_o);

  // R1
  busy_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_l_n_o || !busy_r_n_o) |->
      $past(master_i && l_en_i && r_en_i && (l_addr_i == r_addr_i)));

  // R7
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!master_i) |-> (busy_l_n_o && busy_r_n_o));

  // R6
  busy_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_i && (!busy_l_n_o || !busy_r_n_o)) |->
      !((!busy_l_n_o && l_we_o) || (!busy_r_n_o && r_we_o)));

endmodule

// File: tb/sim_dp_collision_arb.sv
module sim_dp_collision_arb;
  localparam int AW = 15;
  localparam time TCK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, master = 1'b1;
  logic le = 1'b0, re = 1'b0, lw = 1'b0, rw = 1'b0, bli = 1'b1, bri = 1'b1;
  logic [AW-1:0] la = '0, ra = '0;
  logic bl, br, lwo, rwo;

  int vec = 0, bad = 0;
  logic [AW-1:0] pla = '0, pra = '0;
  logic ple = 1'b0, pre = 1'b0, rfirst = 1'b0, ebl = 1'b1, ebr = 1'b1;

  always #(TCK/2) clk = ~clk;

  dp_collision_arb #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_i(master),
    .l_en_i(le), .l_addr_i(la), .l_we_i(lw),
    .r_en_i(re), .r_addr_i(ra), .r_we_i(rw),
    .busy_l_n_i(bli), .busy_r_n_i(bri),
    .busy_l_n_o(bl), .busy_r_n_o(br), .l_we_o(lwo), .r_we_o(rwo));

  task automatic chk(string tag, string what, logic act, logic exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  function automatic logic exp_wr(logic we, logic ms, logic own, logic ext);
    return we && (ms ? own : ext);
  endfunction

  task automatic step(string tag);
    logic lc, rc, m;
    @(posedge clk);
    #1;
    lc = (la != pla) || (le != ple);
    rc = (ra != pra) || (re != pre);
    if (rc) rfirst = 1'b0;
    else if (lc) rfirst = 1'b1;
    m = master && le && re && (la == ra);
    ebl = !(m && rfirst);
    ebr = !(m && !rfirst);
    pla = la; pra = ra; ple = le; pre = re;
    chk(tag != "" ? tag : (master ? (m ? "R3" : "R2") : "R7"), "busy_l", bl, ebl);
    chk(tag != "" ? tag : (master ? (m ? "R3" : "R2") : "R7"), "busy_r", br, ebr);
    chk(master ? "R6" : "R7", "l_we", lwo, exp_wr(lw, master, ebl, bli));
    chk(master ? "R6" : "R7", "r_we", rwo, exp_wr(rw, master, ebr, bri));
    chk("R5", "not both low", bl || br, 1'b1);
  endtask

  task automatic drive(logic ms, logic e0, logic [AW-1:0] a0, logic w0,
                       logic e1, logic [AW-1:0] a1, logic w1);
    @(negedge clk);
    master = ms; le = e0; la = a0; lw = w0; re = e1; ra = a1; rw = w1;
  endtask

  initial begin
    #(TCK * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "busy_l in reset", bl, 1'b1);
    chk("R9", "busy_r in reset", br, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    step("R9");

    // left settles first, right arrives later with a write -> right busy, write blocked
    drive(1, 1, 15'h0005, 1, 0, 15'h0005, 0); step("R2");
    drive(1, 1, 15'h0005, 1, 1, 15'h0005, 1); step("R3");
    chk("R3", "right busy after late arrival", br, 1'b0);
    chk("R6", "right write blocked", rwo, 1'b0);
    drive(1, 1, 15'h0005, 1, 1, 15'h0005, 1); step("R3");
    // mismatch releases next cycle
    drive(1, 1, 15'h0005, 1, 1, 15'h0006, 1); step("R8");
    chk("R8", "right released", br, 1'b1);
    // simultaneous change onto same address -> left wins
    drive(1, 1, 15'h7ffe, 1, 1, 15'h7ffe, 1); step("R4");
    chk("R4", "right loses tie", br, 1'b0);
    chk("R4", "left kept", bl, 1'b1);
    // enable drop releases
    drive(1, 1, 15'h7ffe, 1, 0, 15'h7ffe, 1); step("R8");
    // right first, left moves later -> left busy
    drive(1, 0, 15'h0001, 0, 1, 15'h0100, 0); step("R2");
    drive(1, 1, 15'h0100, 1, 1, 15'h0100, 0); step("R3");
    chk("R6", "left write blocked", lwo, 1'b0);
    // slave mode: outputs high, external busy gates writes
    bli = 1'b0; bri = 1'b1;
    drive(0, 1, 15'h0100, 1, 1, 15'h0100, 1); step("R7");
    chk("R7", "slave left write blocked", lwo, 1'b0);
    chk("R7", "slave right write passes", rwo, 1'b1);
    // disabled port on equal address never busy
    drive(1, 0, 15'h0100, 1, 1, 15'h0100, 1); step("R1");

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      master = ($urandom % 8) != 0;
      if ($urandom % 3 == 0) begin le = $urandom % 4 != 0; la = AW'($urandom % 4); end
      if ($urandom % 3 == 0) begin re = $urandom % 4 != 0; ra = AW'($urandom % 4); end
      lw = $urandom % 2; rw = $urandom % 2;
      bli = $urandom % 2; bri = $urandom % 2;
      step("");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule